// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel that sits beside a free-running counter. The counter value, a one-cycle capture edge strobe and an update event strobe arrive from outside. Software reaches the channel through a small register port with write, read, address and data signals. The channel keeps two value registers. The preload register is the only one the bus can see. The shadow register is the one that touches the counter.

In capture mode, an accepted edge latches the counter into the shadow register. The shadow contents then move into the preload register, and a capture flag is raised. A capture that lands while the flag is still set also raises an over-capture flag. The channel offers a level interrupt request and a one-cycle DMA request pulse. In compare mode, the preload value reaches the shadow register either at once on a write or at the next update strobe. Two outputs, counter-equal and counter-greater, then feed a downstream output stage.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset the control register, both flags, the preload register and the shadow register are zero. The reset mode is capture with the channel disabled, so irq_req, dma_req, cmp_eq and cmp_gt are all 0.
- R2: Register addresses: 0 is control, 1 is flags, 2 is the value register, and 3 reads as zero and ignores writes. Control bits: bit0 is the channel enable, bit1 selects the mode (1 compare, 0 capture), bit2 is preload enable, bit3 is interrupt enable and bit4 is DMA enable. Flag bits: bit0 is the capture flag and bit1 is over-capture. A bus write to address 2 sets the preload register. bus_rdata is combinational from bus_addr, and a read of address 2 always returns the preload register.
- R3: An edge strobe sampled at clock edge k, while the channel is enabled in capture mode, puts the cnt_val of that cycle into the shadow register at edge k. That value moves into the preload register at edge k+1, and the capture flag is set at edge k+1.
- R4: An edge strobe while the channel is disabled, or while it is in compare mode, changes neither the preload register nor either flag.
- R5: If the copy at edge k+1 finds the capture flag already set, and the flag is not being cleared in that cycle, the over-capture flag is set.
- R6: The capture flag clears when bit0 is written as 0 at address 1, or when address 2 is read. The over-capture flag clears only when bit1 is written as 0 at address 1. Writing 1 to a flag bit leaves it unchanged.
- R7: When a capture copy and a clear of the capture flag fall in the same cycle, the capture wins and the flag stays set. A capture copy also wins over a bus write to address 2 in the same cycle.
- R8: irq_req equals the capture flag ANDed with the interrupt enable.
- R9: dma_req is high for exactly the one cycle that follows each capture copy edge, and only if the DMA enable is set.
- R10: In compare mode with preload enable clear, a write to address 2 loads the shadow register at the same clock edge.
- R11: In compare mode with preload enable set, the shadow register takes the preload value only at an edge where upd_stb is high. At all other edges it holds.
- R12: In compare mode, cmp_eq is (cnt_val == shadow) and cmp_gt is (cnt_val > shadow), compared unsigned and combinationally. In capture mode both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used for the read side effect) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, combinational from bus_addr |
| cnt_val | input | W | Current value of the counter |
| edge_stb | input | 1 | One-cycle conditioned capture edge |
| upd_stb | input | 1 | Update event strobe for the compare preload |
| irq_req | output | 1 | Interrupt request level |
| dma_req | output | 1 | One-cycle DMA request pulse per capture |
| cmp_eq | output | 1 | Counter equals the shadow compare value |
| cmp_gt | output | 1 | Counter greater than the shadow compare value |

## Verification
The bench aims at collisions. These include a capture copy in the same cycle as a flag-clear write or a value read; a design that let the clear win would lose a capture. It also sends back-to-back edges: without the over-capture set, the channel would silently overwrite unread data. In addition, the bench reads the value register while over-capture is pending, to catch a read that wrongly clears it. In compare mode, it hits the counter at the shadow value and one above and one below, and it writes with preload enabled but no update strobe. A channel that moved the shadow early would show the wrong cmp_eq at exactly those points.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_VAL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Packed MSB first: chan_en ends up at bit 0.
  typedef struct packed {
    logic dma_en;
    logic irq_en;
    logic pre_en;
    logic cmp_mode;
    logic chan_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int FLAG_CAP_BIT = 0;
  localparam int FLAG_OVR_BIT = 1;

  // Capture flag next state: a capture beats a clear.
  function automatic logic f_cap_next(input logic evt, input logic cur, input logic clr);
    return evt | (cur & ~clr);
  endfunction

  // Over-capture next state: set beats clear.
  function automatic logic f_ovr_next(input logic evt, input logic cap, input logic clr_cap,
                                      input logic cur, input logic clr_ovr);
    return (evt & cap & ~clr_cap) | (cur & ~clr_ovr);
  endfunction

endpackage

// File: rtl/tmr_cc_bus.sv
module tmr_cc_bus
  import tmr_cc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] ctl_wdata,
  input  logic              cap_flag,
  input  logic              ovr_flag,
  input  logic [W-1:0]      preload,
  output ctrl_t             ctrl,
  output logic              val_wr,
  output logic              clr_cap,
  output logic              clr_ovr,
  output logic [W-1:0]      bus_rdata
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  logic ctrl_wr, flag_wr, val_rd;
  assign ctrl_wr = bus_wr & (sel == SEL_CTRL);
  assign flag_wr = bus_wr & (sel == SEL_FLAG);
  assign val_wr  = bus_wr & (sel == SEL_VAL);
  assign val_rd  = bus_rd & (sel == SEL_VAL);

  // A flag clears on a written zero; a written one keeps it.
  assign clr_cap = (flag_wr & ~ctl_wdata[FLAG_CAP_BIT]) | val_rd;
  assign clr_ovr = flag_wr & ~ctl_wdata[FLAG_OVR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (ctrl_wr) ctrl <= ctrl_t'(ctl_wdata);
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_CTRL: bus_rdata[CTRL_W-1:0] = ctrl;
      SEL_FLAG: begin
        bus_rdata[FLAG_CAP_BIT] = cap_flag;
        bus_rdata[FLAG_OVR_BIT] = ovr_flag;
      end
      SEL_VAL:  bus_rdata = preload;
      default:  bus_rdata = '0;
    endcase
  end

  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl == $past(ctl_wdata));
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl));

endmodule

// File: rtl/tmr_cc_store.sv
module tmr_cc_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chan_en,
  input  logic         cmp_mode,
  input  logic         pre_en,
  input  logic         edge_stb,
  input  logic         upd_stb,
  input  logic [W-1:0] cnt_val,
  input  logic         val_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] preload,
  output logic [W-1:0] shadow,
  output logic         cap_evt
);

  logic cap_ok;      // edge accepted this cycle
  logic cap_pend;    // shadow holds a fresh capture awaiting copy
  logic cmp_direct;  // compare write goes straight through
  logic cmp_update;  // compare update event transfers preload

  assign cap_ok     = edge_stb & chan_en & ~cmp_mode;
  assign cmp_direct = cmp_mode & ~pre_en & val_wr;
  assign cmp_update = cmp_mode & pre_en & upd_stb;
  assign cap_evt    = cap_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_pend <= 1'b0;
    else        cap_pend <= cap_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shadow <= '0;
    else if (cap_ok)     shadow <= cnt_val;
    else if (cmp_direct) shadow <= wdata;
    else if (cmp_update) shadow <= preload;
  end

  // Capture copy has priority over a bus write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        preload <= '0;
    else if (cap_pend) preload <= shadow;
    else if (val_wr)   preload <= wdata;
  end

  a_r3_shadow_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ok |=> shadow == $past(cnt_val));
  a_r3_copy_to_preload: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> preload == $past(shadow));
  a_r7_copy_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && val_wr) |=> preload != $past(wdata) || $past(wdata) == $past(shadow));
  a_r2_write_preload: assert property (@(posedge clk) disable iff (!rst_n)
    (val_wr && !cap_evt) |=> preload == $past(wdata));
  a_r10_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && !pre_en && val_wr) |=> shadow == $past(wdata));
  a_r11_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && pre_en && !upd_stb) |=> $stable(shadow));

endmodule

// File: rtl/tmr_cc_flags.sv
module tmr_cc_flags
  import tmr_cc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_evt,
  input  logic clr_cap,
  input  logic clr_ovr,
  input  logic irq_en,
  input  logic dma_en,
  output logic cap_flag,
  output logic ovr_flag,
  output logic irq_req,
  output logic dma_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      cap_flag <= f_cap_next(cap_evt, cap_flag, clr_cap);
      ovr_flag <= f_ovr_next(cap_evt, cap_flag, clr_cap, ovr_flag, clr_ovr);
      dma_req  <= cap_evt & dma_en;
    end
  end

  assign irq_req = cap_flag & irq_en;

  a_r7_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag);
  a_r5_overcapture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && cap_flag && !clr_cap) |=> ovr_flag);
  a_r6_clear_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cap && !cap_evt) |=> !cap_flag);
  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr_ovr) |=> ovr_flag);
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> cap_flag);
  a_r9_dma_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(cap_evt));

endmodule

// File: rtl/tmr_cc_cmp.sv
module tmr_cc_cmp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_mode,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] shadow,
  output logic         cmp_eq,
  output logic         cmp_gt
);

  function automatic logic f_same(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  function automatic logic f_above(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] diff;
    diff = {1'b0, b} - {1'b0, a};  // borrow set when a > b
    return diff[W];
  endfunction

  assign cmp_eq = cmp_mode & f_same(cnt_val, shadow);
  assign cmp_gt = cmp_mode & f_above(cnt_val, shadow);

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_eq && cmp_gt));
  a_r12_quiet_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_mode |-> !cmp_eq && !cmp_gt);

endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
  import tmr_cc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] cnt_val,
  input  logic         edge_stb,
  input  logic         upd_stb,
  output logic         irq_req,
  output logic         dma_req,
  output logic         cmp_eq,
  output logic         cmp_gt
);

  ctrl_t        ctrl;
  logic         val_wr, clr_cap, clr_ovr;
  logic         cap_flag, ovr_flag, cap_evt;
  logic [W-1:0] preload, shadow;

  tmr_cc_bus #(.W(W)) u_bus (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .ctl_wdata(bus_wdata[CTRL_W-1:0]),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag), .preload(preload),
    .ctrl(ctrl), .val_wr(val_wr), .clr_cap(clr_cap), .clr_ovr(clr_ovr),
    .bus_rdata(bus_rdata)
  );

  tmr_cc_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .chan_en(ctrl.chan_en), .cmp_mode(ctrl.cmp_mode),
    .pre_en(ctrl.pre_en), .edge_stb(edge_stb), .upd_stb(upd_stb),
    .cnt_val(cnt_val), .val_wr(val_wr), .wdata(bus_wdata),
    .preload(preload), .shadow(shadow), .cap_evt(cap_evt)
  );

  tmr_cc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .clr_cap(clr_cap),
    .clr_ovr(clr_ovr), .irq_en(ctrl.irq_en), .dma_en(ctrl.dma_en),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag), .irq_req(irq_req), .dma_req(dma_req)
  );

  tmr_cc_cmp #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cmp_mode(ctrl.cmp_mode), .cnt_val(cnt_val),
    .shadow(shadow), .cmp_eq(cmp_eq), .cmp_gt(cmp_gt)
  );

  a_r4_edge_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_stb && !(ctrl.chan_en && !ctrl.cmp_mode)) |=> !cap_evt);
  a_r4_no_flag_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !cap_flag) |=> !cap_flag);

endmodule

// File: tb/tb_tmr_cc_channel.sv
module tb_tmr_cc_channel;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, edge_stb = 0, upd_stb = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, cnt_val = 0;
  logic [W-1:0] bus_rdata;
  logic irq_req, dma_req, cmp_eq, cmp_gt;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_cc_channel #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt_val),
    .edge_stb(edge_stb), .upd_stb(upd_stb), .irq_req(irq_req), .dma_req(dma_req),
    .cmp_eq(cmp_eq), .cmp_gt(cmp_gt)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // Model state, kept from the requirements.
  logic [4:0]   m_ctrl = 0;
  logic         m_cap = 0, m_ovr = 0, m_pend = 0, m_dma = 0;
  logic [W-1:0] m_pre = 0, m_sh = 0;

  function automatic logic [W-1:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0: return {{(W-5){1'b0}}, m_ctrl};
      2'd1: return {{(W-2){1'b0}}, m_ovr, m_cap};
      2'd2: return m_pre;
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_eq(input logic [W-1:0] c);
    return m_ctrl[1] && (c == m_sh);
  endfunction

  function automatic logic exp_gt(input logic [W-1:0] c);
    return m_ctrl[1] && (c > m_sh);
  endfunction

  task automatic check(input string t, input string what, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", t, what, got, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare, then step the model at the rising edge.
  task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                     input logic [W-1:0] wd, input logic edg, input logic upd,
                     input logic [W-1:0] cnt);
    logic cap_ok, clr_c, clr_o;
    logic [W-1:0] n_sh, n_pre;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    edge_stb = edg; upd_stb = upd; cnt_val = cnt;
    #1;
    check(tag, "rdata", bus_rdata, exp_rdata(a));
    check("R8", "irq_req", W'(irq_req), W'(m_cap & m_ctrl[3]));
    check("R9", "dma_req", W'(dma_req), W'(m_dma));
    check("R12", "cmp_eq", W'(cmp_eq), W'(exp_eq(cnt)));
    check("R12", "cmp_gt", W'(cmp_gt), W'(exp_gt(cnt)));
    @(posedge clk);
    cap_ok = edg & m_ctrl[0] & ~m_ctrl[1];
    clr_c  = (wr && a == 2'd1 && !wd[0]) || (rd && a == 2'd2);
    clr_o  = wr && a == 2'd1 && !wd[1];
    n_sh = m_sh;
    if (cap_ok) n_sh = cnt;
    else if (m_ctrl[1] && !m_ctrl[2] && wr && a == 2'd2) n_sh = wd;
    else if (m_ctrl[1] && m_ctrl[2] && upd) n_sh = m_pre;
    n_pre = m_pend ? m_sh : ((wr && a == 2'd2) ? wd : m_pre);
    m_dma = m_pend & m_ctrl[4];
    m_ovr = (m_pend & m_cap & ~clr_c) | (m_ovr & ~clr_o);
    m_cap = m_pend | (m_cap & ~clr_c);
    m_pend = cap_ok;
    m_sh = n_sh; m_pre = n_pre;
    if (wr && a == 2'd0) m_ctrl = wd[4:0];
  endtask

  task automatic idle(input logic [1:0] a);
    cyc(0, 0, a, 0, 0, 0, 0);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [W-1:0] d);
    cyc(1, 0, a, d, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    tag = "R1";
    idle(2'd0); idle(2'd1); idle(2'd2);
    check("R1", "cmp_eq at reset", W'(cmp_eq), 0);

    // R2 register access
    tag = "R2";
    wreg(2'd2, 16'h1234);
    idle(2'd2);
    check("R2", "preload readback", bus_rdata, 16'h1234);
    wreg(2'd3, 16'hFFFF);
    idle(2'd3);
    check("R2", "reserved reads zero", bus_rdata, 16'h0000);
    wreg(2'd0, 16'h0019);   // dma_en, irq_en, chan_en; capture mode
    idle(2'd0);
    check("R2", "ctrl readback", bus_rdata, 16'h0019);

    // R3 capture timing
    tag = "R3";
    cyc(0, 0, 2'd1, 0, 1, 0, 16'h0ABC);
    idle(2'd1);
    idle(2'd2);
    check("R3", "captured value", bus_rdata, 16'h0ABC);
    check("R9", "dma pulse cycle", W'(dma_req), 1);
    check("R8", "irq with flag", W'(irq_req), 1);
    // R6 read of value register clears the capture flag
    tag = "R6";
    cyc(0, 1, 2'd2, 0, 0, 0, 0);
    idle(2'd1);
    check("R6", "flag cleared by read", bus_rdata, 16'h0000);
    check("R9", "dma single cycle", W'(dma_req), 0);

    // R5 over-capture with back-to-back edges
    tag = "R5";
    cyc(0, 0, 2'd1, 0, 1, 0, 16'h0100);
    cyc(0, 0, 2'd1, 0, 1, 0, 16'h0200);
    idle(2'd1); idle(2'd1);
    check("R5", "both flags", bus_rdata, 16'h0003);
    tag = "R6";
    cyc(0, 1, 2'd2, 0, 0, 0, 0);
    check("R3", "latest capture", bus_rdata, 16'h0200);
    idle(2'd1);
    check("R6", "read keeps over-capture", bus_rdata, 16'h0002);
    wreg(2'd1, 16'h0003);   // ones change nothing
    idle(2'd1);
    check("R6", "write one keeps", bus_rdata, 16'h0002);
    wreg(2'd1, 16'h0001);   // zero in bit1 clears over-capture
    idle(2'd1);
    check("R6", "over-capture cleared", bus_rdata, 16'h0000);

    // R7 capture against a clear in the same cycle
    tag = "R7";
    cyc(0, 0, 2'd1, 0, 1, 0, 16'h0333);
    wreg(2'd1, 16'h0000);   // clear lands on the copy edge
    idle(2'd1);
    check("R7", "capture beats clear", bus_rdata, 16'h0001);
    cyc(0, 0, 2'd1, 0, 1, 0, 16'h0444);
    wreg(2'd2, 16'h5555);   // write lands on the copy edge
    idle(2'd2);
    check("R7", "capture beats write", bus_rdata, 16'h0444);
    wreg(2'd1, 16'h0000);

    // R4 ignored edges
    tag = "R4";
    wreg(2'd0, 16'h0018);   // disabled
    cyc(0, 0, 2'd1, 0, 1, 0, 16'h0777);
    idle(2'd1); idle(2'd1);
    check("R4", "disabled no flag", bus_rdata, 16'h0000);
    idle(2'd2);
    check("R4", "disabled no value", bus_rdata, 16'h0444);
    check("R8", "irq low", W'(irq_req), 0);

    // R10 compare, direct write
    tag = "R10";
    wreg(2'd0, 16'h0003);   // compare, enabled, no preload
    cyc(0, 0, 2'd1, 0, 1, 0, 16'h0888);   // R4 edge in compare mode
    wreg(2'd2, 16'h0050);
    idle(2'd1);
    check("R4", "compare-mode edge no flag", bus_rdata, 16'h0000);
    cyc(0, 0, 2'd2, 0, 0, 0, 16'h0050);
    check("R10", "eq right after write", W'(cmp_eq), 1);
    cyc(0, 0, 2'd2, 0, 0, 0, 16'h0051);
    check("R12", "gt one above", W'(cmp_gt), 1);
    cyc(0, 0, 2'd2, 0, 0, 0, 16'h004F);
    check("R12", "below gives neither", W'(cmp_gt | cmp_eq), 0);

    // R11 compare with preload
    tag = "R11";
    wreg(2'd0, 16'h0007);
    wreg(2'd2, 16'h0090);
    cyc(0, 0, 2'd2, 0, 0, 0, 16'h0050);
    check("R11", "shadow held before update", W'(cmp_eq), 1);
    cyc(0, 0, 2'd2, 0, 0, 1, 16'h0090);
    cyc(0, 0, 2'd2, 0, 0, 0, 16'h0090);
    check("R11", "shadow after update", W'(cmp_eq), 1);
    cyc(0, 0, 2'd2, 0, 0, 0, 16'hFFFF);
    check("R12", "max counter above", W'(cmp_gt), 1);

    // Random mix against the model
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic wr, rd, edg, upd;
      logic [1:0] a;
      logic [W-1:0] wd, cnt;
      r   = $urandom % 100;
      wr  = r < 12;
      rd  = r >= 12 && r < 30;
      a   = 2'($urandom % 4);
      wd  = W'($urandom);
      if (wr && a == 2'd0) wd[0] = ($urandom % 5) != 0;
      edg = ($urandom % 4) == 0;
      upd = ($urandom % 6) == 0;
      if (($urandom % 3) == 0) cnt = m_sh + W'($urandom % 3) - W'(1);
      else cnt = W'($urandom);
      cyc(wr, rd, a, wd, edg, upd, cnt);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule